// File: doc/BRIEF.md
# Register Rename Status Table

This block holds the architectural register file of an out-of-order core together with one status entry per register. The status entry says whether a result is still owed to that register and, if so, which reservation station will produce it. Each register that the issue stage reads is looked up through one of two source ports. A settled register returns its stored value, marked ready. A register with a result still owed returns the tag of the station that will produce it, marked not ready. The issue stage can then park that tag in the consuming station.

When an instruction issues, the destination port writes the station's tag into the status of the target register. This renames the register to that station. A later writer to the same register overwrites the tag, so only the newest producer is ever recorded. The table also watches the result broadcast bus, which carries a producing tag and its data. An entry that still names the broadcast tag takes the data into the register and becomes settled again. An entry that names a different tag, or no tag, ignores the broadcast.

Lookups are combinational and see the state held before the current cycle's updates. The one exception is a matching broadcast in the same cycle: its data is forwarded at once. All state updates take effect at the next rising clock edge.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register reads as ready with value zero on both source ports.
- R2: A source lookup of a settled register returns ready = 1 and the register's stored value.
- R3: A source lookup of a register waiting on a producer returns ready = 0 and that producer's tag, unless a matching broadcast is present in the same cycle.
- R4: An issue with dst_we = 1 marks register dst_idx as waiting on dst_tag from the next cycle on.
- R5: A second issue to the same register replaces the earlier tag. A later broadcast of the earlier tag leaves the register waiting on the newer tag, with its value unchanged.
- R6: A broadcast whose tag equals a waiting register's tag writes bc_data into that register and makes it settled from the next cycle on.
- R7: A broadcast whose tag matches no waiting register leaves every status entry and every value unchanged.
- R8: When an issue to a register and a broadcast matching that register's current tag occur in the same cycle, the register ends up waiting on the newly issued tag.
- R9: A source lookup of a waiting register in the same cycle as a broadcast of its tag returns ready = 1 with bc_data.
- R10: A source lookup in the same cycle as an issue to the same register returns the status held before that issue.
- R11: The two source ports answer independently, each for its own index, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_idx | input | 4 | Register index looked up on port A |
| src_a_ready | output | 1 | Port A operand is a value (1) or a pending tag (0) |
| src_a_value | output | 32 | Port A operand value when ready |
| src_a_tag | output | 4 | Port A producer tag when not ready |
| src_b_idx | input | 4 | Register index looked up on port B |
| src_b_ready | output | 1 | Port B operand is a value (1) or a pending tag (0) |
| src_b_value | output | 32 | Port B operand value when ready |
| src_b_tag | output | 4 | Port B producer tag when not ready |
| dst_we | input | 1 | Issue writes a destination this cycle |
| dst_idx | input | 4 | Destination register of the issuing instruction |
| dst_tag | input | 4 | Tag of the issuing reservation station |
| bc_valid | input | 1 | Result broadcast present this cycle |
| bc_tag | input | 4 | Tag of the station producing the broadcast |
| bc_data | input | 32 | Result data of the broadcast |

## Verification
The assertions assume that a station tag is owed to at most one register at a time. They also assume that the issue stage never hands out a tag whose result has not yet been broadcast. This holds in a real core, because a station stays busy until it writes its result. The stimulus keeps to this rule by tracking which stations are busy. It issues only free tags, and it broadcasts either a busy tag, which frees that station, or an idle tag, which exercises the no-match case. Directed cycles come before the random phase and place issue, broadcast and lookup on the same register in the same cycle.

// File: rtl/rst_pkg.sv
package rst_pkg;

   // How a source operand is produced on a read port
   typedef enum logic [1:0] {
      SRC_STORED = 2'd0,
      SRC_FORWARD = 2'd1,
      SRC_WAIT = 2'd2
   } src_kind_e;

   localparam int DEF_NREGS = 16;
   localparam int DEF_DW = 32;
   localparam int DEF_TW = 4;

endpackage

// File: rtl/rst_entry.sv
module rst_entry #(
   parameter int DW = 32,
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dst_hit,
   input  logic [TW-1:0] dst_tag,
   input  logic          bc_valid,
   input  logic [TW-1:0] bc_tag,
   input  logic [DW-1:0] bc_data,
   output logic          pend_o,
   output logic [TW-1:0] tag_o,
   output logic [DW-1:0] val_o
);

   logic          pend_q;
   logic [TW-1:0] tag_q;
   logic [DW-1:0] val_q;
   logic          snoop_hit;

   assign snoop_hit = bc_valid && pend_q && (tag_q == bc_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         tag_q  <= '0;
         val_q  <= '0;
      end else begin
         if (snoop_hit) begin
            val_q  <= bc_data;
            pend_q <= 1'b0;
         end
         // a fresh issue overrides a same-cycle clear
         if (dst_hit) begin
            pend_q <= 1'b1;
            tag_q  <= dst_tag;
         end
      end
   end

   assign pend_o = pend_q;
   assign tag_o  = tag_q;
   assign val_o  = val_q;

endmodule

// File: rtl/rst_read_port.sv
module rst_read_port
   import rst_pkg::*;
#(
   parameter int NREGS = 16,
   parameter int DW = 32,
   parameter int TW = 4,
   parameter int AW = 4,
   parameter bit BYPASS = 1'b1
) (
   input  logic [AW-1:0]             idx,
   input  logic [NREGS-1:0]          pend_vec,
   input  logic [NREGS-1:0][TW-1:0]  tag_arr,
   input  logic [NREGS-1:0][DW-1:0]  val_arr,
   input  logic                      bc_valid,
   input  logic [TW-1:0]             bc_tag,
   input  logic [DW-1:0]             bc_data,
   output logic                      ready,
   output logic [DW-1:0]             value,
   output logic [TW-1:0]             tag
);

   logic          in_range;
   logic          sel_pend;
   logic [TW-1:0] sel_tag;
   logic [DW-1:0] sel_val;
   logic          fwd_hit;
   src_kind_e     kind;

   assign in_range = (32'(idx) < NREGS);

   always_comb begin
      sel_pend = 1'b0;
      sel_tag  = '0;
      sel_val  = '0;
      if (in_range) begin
         sel_pend = pend_vec[idx];
         sel_tag  = tag_arr[idx];
         sel_val  = val_arr[idx];
      end
   end

   generate
      if (BYPASS) begin : g_fwd
         assign fwd_hit = bc_valid && (bc_tag == sel_tag);
      end else begin : g_nofwd
         assign fwd_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!sel_pend)    kind = SRC_STORED;
      else if (fwd_hit) kind = SRC_FORWARD;
      else              kind = SRC_WAIT;
   end

   always_comb begin
      ready = 1'b1;
      value = sel_val;
      tag   = sel_tag;
      unique case (kind)
         SRC_STORED:  value = sel_val;
         SRC_FORWARD: value = bc_data;
         default: begin
            ready = 1'b0;
            value = '0;
         end
      endcase
   end

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
   import rst_pkg::*;
#(
   parameter int NREGS = DEF_NREGS,
   parameter int DW = DEF_DW,
   parameter int TW = DEF_TW,
   parameter bit BYPASS = 1'b1,
   localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] src_a_idx,
   output logic          src_a_ready,
   output logic [DW-1:0] src_a_value,
   output logic [TW-1:0] src_a_tag,
   input  logic [AW-1:0] src_b_idx,
   output logic          src_b_ready,
   output logic [DW-1:0] src_b_value,
   output logic [TW-1:0] src_b_tag,
   input  logic          dst_we,
   input  logic [AW-1:0] dst_idx,
   input  logic [TW-1:0] dst_tag,
   input  logic          bc_valid,
   input  logic [TW-1:0] bc_tag,
   input  logic [DW-1:0] bc_data
);

   generate
      if (NREGS < 2) begin : g_bad_nregs
         $error("rename_status_table: NREGS must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("rename_status_table: DW must be positive");
      end
      if (TW < 1 || TW > 16) begin : g_bad_tw
         $error("rename_status_table: TW must be in 1..16");
      end
   endgenerate

   logic [NREGS-1:0]         pend_vec;
   logic [NREGS-1:0][TW-1:0] tag_arr;
   logic [NREGS-1:0][DW-1:0] val_arr;

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_ent
         localparam logic [AW-1:0] MY_IDX = AW'(i);
         logic hit;
         assign hit = dst_we && (dst_idx == MY_IDX);
         rst_entry #(.DW(DW), .TW(TW)) ent_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .dst_hit  (hit),
            .dst_tag  (dst_tag),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .pend_o   (pend_vec[i]),
            .tag_o    (tag_arr[i]),
            .val_o    (val_arr[i])
         );
      end
   endgenerate

   rst_read_port #(.NREGS(NREGS), .DW(DW), .TW(TW), .AW(AW), .BYPASS(BYPASS)) rd_a_i (
      .idx      (src_a_idx),
      .pend_vec (pend_vec),
      .tag_arr  (tag_arr),
      .val_arr  (val_arr),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .ready    (src_a_ready),
      .value    (src_a_value),
      .tag      (src_a_tag)
   );

   rst_read_port #(.NREGS(NREGS), .DW(DW), .TW(TW), .AW(AW), .BYPASS(BYPASS)) rd_b_i (
      .idx      (src_b_idx),
      .pend_vec (pend_vec),
      .tag_arr  (tag_arr),
      .val_arr  (val_arr),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .ready    (src_b_ready),
      .value    (src_b_value),
      .tag      (src_b_tag)
   );

endmodule

// File: rtl/rst_checker.sv
module rst_checker #(
   parameter int NREGS = 16,
   parameter int DW = 32,
   parameter int TW = 4,
   parameter int AW = 4,
   parameter bit BYPASS = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [AW-1:0]            src_a_idx,
   input logic                     src_a_ready,
   input logic [DW-1:0]            src_a_value,
   input logic [TW-1:0]            src_a_tag,
   input logic                     dst_we,
   input logic [AW-1:0]            dst_idx,
   input logic [TW-1:0]            dst_tag,
   input logic                     bc_valid,
   input logic [TW-1:0]            bc_tag,
   input logic [DW-1:0]            bc_data,
   input logic [NREGS-1:0]         pend_vec,
   input logic [NREGS-1:0][TW-1:0] tag_arr,
   input logic [NREGS-1:0][DW-1:0] val_arr
);

   logic a_in;
   assign a_in = (32'(src_a_idx) < NREGS);

   // R2: settled register reads its stored value
   a_r2_settled_reads_value: assert property (@(posedge clk) disable iff (!rst_n)
      (a_in && !pend_vec[src_a_idx]) |-> (src_a_ready && src_a_value == val_arr[src_a_idx]));

   // R3: waiting register reads its producer tag
   a_r3_waiting_reads_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (a_in && pend_vec[src_a_idx] && !(bc_valid && bc_tag == tag_arr[src_a_idx]))
      |-> (!src_a_ready && src_a_tag == tag_arr[src_a_idx]));

   generate
      if (BYPASS) begin : g_fwd_chk
         // R9: matching broadcast is forwarded on the lookup
         a_r9_forward_on_match: assert property (@(posedge clk) disable iff (!rst_n)
            (a_in && pend_vec[src_a_idx] && bc_valid && bc_tag == tag_arr[src_a_idx])
            |-> (src_a_ready && src_a_value == bc_data));
      end
      for (genvar i = 0; i < NREGS; i++) begin : g_ent_chk
         localparam logic [AW-1:0] MY_IDX = AW'(i);
         // R4, R8: an issue always leaves the register waiting on the new tag
         a_r4_issue_renames: assert property (@(posedge clk) disable iff (!rst_n)
            (dst_we && dst_idx == MY_IDX) |=> (pend_vec[i] && tag_arr[i] == $past(dst_tag)));
         // R6: matching broadcast fills and settles
         a_r6_broadcast_fills: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_valid && pend_vec[i] && tag_arr[i] == bc_tag && !(dst_we && dst_idx == MY_IDX))
            |=> (!pend_vec[i] && val_arr[i] == $past(bc_data)));
         // R5, R7: a waiting register untouched by issue or matching broadcast holds
         a_r7_waiting_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_vec[i] && !(bc_valid && bc_tag == tag_arr[i]) && !(dst_we && dst_idx == MY_IDX))
            |=> (pend_vec[i] && tag_arr[i] == $past(tag_arr[i]) && $stable(val_arr[i])));
      end
   endgenerate

endmodule

bind rename_status_table rst_checker #(
   .NREGS(NREGS), .DW(DW), .TW(TW), .AW(AW), .BYPASS(BYPASS)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_a_idx   (src_a_idx),
   .src_a_ready (src_a_ready),
   .src_a_value (src_a_value),
   .src_a_tag   (src_a_tag),
   .dst_we      (dst_we),
   .dst_idx     (dst_idx),
   .dst_tag     (dst_tag),
   .bc_valid    (bc_valid),
   .bc_tag      (bc_tag),
   .bc_data     (bc_data),
   .pend_vec    (pend_vec),
   .tag_arr     (tag_arr),
   .val_arr     (val_arr)
);

// File: tb/rename_status_table_tb.sv
module rename_status_table_tb_top;

   localparam int NREGS = 16;
   localparam int DW = 32;
   localparam int TW = 4;
   localparam int AW = 4;
   localparam int NST = 1 << TW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
   logic          src_a_ready, src_b_ready;
   logic [DW-1:0] src_a_value, src_b_value;
   logic [TW-1:0] src_a_tag, src_b_tag;
   logic          dst_we = 1'b0, bc_valid = 1'b0;
   logic [TW-1:0] dst_tag = '0, bc_tag = '0;
   logic [DW-1:0] bc_data = '0;

   always #5 clk = ~clk;

   rename_status_table dut_i (
      .clk(clk), .rst_n(rst_n),
      .src_a_idx(src_a_idx), .src_a_ready(src_a_ready), .src_a_value(src_a_value), .src_a_tag(src_a_tag),
      .src_b_idx(src_b_idx), .src_b_ready(src_b_ready), .src_b_value(src_b_value), .src_b_tag(src_b_tag),
      .dst_we(dst_we), .dst_idx(dst_idx), .dst_tag(dst_tag),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data)
   );

   // behavioural reference
   bit            m_pend [NREGS];
   int unsigned   m_tag [NREGS];
   logic [DW-1:0] m_val [NREGS];
   bit            m_busy [NST];
   int            n_checks = 0;
   int            n_fail = 0;
   bit            finished = 1'b0;

   task automatic check_port(input string lbl, input int idx, input logic rdy,
                             input logic [DW-1:0] val, input logic [TW-1:0] tg);
      bit exp_rdy;
      logic [DW-1:0] exp_val;
      string l;
      l = lbl;
      if (!m_pend[idx]) begin
         exp_rdy = 1'b1; exp_val = m_val[idx];
         if (l == "") l = "R2";
      end else if (bc_valid && int'(bc_tag) == m_tag[idx]) begin
         exp_rdy = 1'b1; exp_val = bc_data;
         if (l == "") l = "R9";
      end else begin
         exp_rdy = 1'b0; exp_val = '0;
         if (l == "") l = "R3";
      end
      if (lbl == "" && dst_we && int'(dst_idx) == idx) l = {l, "/R10"};
      n_checks++;
      if (rdy !== exp_rdy || (exp_rdy && val !== exp_val) || (!exp_rdy && int'(tg) != m_tag[idx])) begin
         n_fail++;
         $display("FAIL %s reg %0d: got ready=%0b value=%h tag=%0d, expected ready=%0b value=%h tag=%0d",
                  l, idx, rdy, val, tg, exp_rdy, exp_val, m_tag[idx]);
      end
   endtask

   task automatic cyc(input int sa, input int sb, input bit dw, input int di, input int dt,
                      input bit bv, input int bt, input logic [DW-1:0] bd, input string lbl);
      @(negedge clk);
      src_a_idx = AW'(sa); src_b_idx = AW'(sb);
      dst_we = dw; dst_idx = AW'(di); dst_tag = TW'(dt);
      bc_valid = bv; bc_tag = TW'(bt); bc_data = bd;
      #1;
      check_port(lbl, sa, src_a_ready, src_a_value, src_a_tag);
      check_port((lbl == "") ? "" : {lbl, " R11"}, sb, src_b_ready, src_b_value, src_b_tag);
      @(posedge clk);
      for (int r = 0; r < NREGS; r++) begin
         if (bv && m_pend[r] && m_tag[r] == bt) begin
            m_val[r] = bd; m_pend[r] = 1'b0;
         end
      end
      if (bv) m_busy[bt] = 1'b0;
      if (dw) begin
         m_pend[di] = 1'b1; m_tag[di] = dt; m_busy[dt] = 1'b1;
      end
   endtask

   initial begin
      for (int r = 0; r < NREGS; r++) begin m_pend[r] = 0; m_tag[r] = 0; m_val[r] = '0; end
      for (int s = 0; s < NST; s++) m_busy[s] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state on every register
      for (int r = 0; r < NREGS; r += 2) cyc(r, r + 1, 0, 0, 0, 0, 0, '0, "R1");
      // R4: issue then look up
      cyc(0, 1, 1, 5, 3, 0, 0, '0, "R4");
      cyc(5, 4, 0, 0, 0, 0, 0, '0, "R4");
      // R5: overwrite tag, old tag broadcast ignored
      cyc(5, 0, 1, 5, 7, 0, 0, '0, "R5");
      cyc(5, 0, 0, 0, 0, 1, 3, 32'hAAAA_0001, "R5");
      cyc(5, 0, 0, 0, 0, 0, 0, '0, "R5");
      // R9 then R6: matching broadcast forwarded, then stored
      cyc(5, 1, 0, 0, 0, 1, 7, 32'h1234_5678, "R9");
      cyc(5, 1, 0, 0, 0, 0, 0, '0, "R6");
      // R8: issue and matching broadcast same cycle
      cyc(0, 0, 1, 2, 1, 0, 0, '0, "R4");
      cyc(2, 5, 1, 2, 9, 1, 1, 32'h0000_0055, "R9");
      cyc(2, 5, 0, 0, 0, 0, 0, '0, "R8");
      cyc(2, 5, 0, 0, 0, 1, 9, 32'h0000_0099, "R9");
      // R7: idle tag broadcast
      cyc(0, 0, 1, 3, 4, 0, 0, '0, "R4");
      cyc(3, 2, 0, 0, 0, 1, 12, 32'hDEAD_BEEF, "R7");
      cyc(3, 2, 0, 0, 0, 0, 0, '0, "R7");
      // R10: lookup sees pre-issue state
      cyc(3, 4, 1, 3, 5, 0, 0, '0, "R10");
      cyc(3, 4, 0, 0, 0, 0, 0, '0, "R10");
      // random phase, tags kept unique per register
      for (int n = 0; n < 4000; n++) begin
         int sa, sb, di, dt, bt;
         bit dw, bv;
         logic [DW-1:0] bd;
         sa = int'($urandom % NREGS); sb = int'($urandom % NREGS);
         bd = $urandom;
         bv = 0; bt = 0;
         if ($urandom % 4 != 0) begin
            int st;
            st = int'($urandom % NST);
            for (int k = 0; k < NST; k++) begin
               if (!bv && m_busy[(st + k) % NST]) begin bv = 1; bt = (st + k) % NST; end
            end
         end
         if (!bv && ($urandom % 5 == 0)) begin
            for (int k = 0; k < NST; k++) if (!bv && !m_busy[k]) begin bv = 1; bt = k; end
         end
         dw = 0; dt = 0;
         if ($urandom % 2 == 0) begin
            int st;
            st = int'($urandom % NST);
            for (int k = 0; k < NST; k++) begin
               int c;
               c = (st + k) % NST;
               if (!dw && !m_busy[c] && !(bv && c == bt)) begin dw = 1; dt = c; end
            end
         end
         di = int'($urandom % NREGS);
         if (bv && ($urandom % 3 == 0)) begin
            for (int r = 0; r < NREGS; r++) if (m_pend[r] && m_tag[r] == bt) di = r;
         end
         cyc(sa, sb, dw, di, dt, bv, bt, bd, "");
      end
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, got no completion, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule